// File: doc/BRIEF.md
# Calibrated seconds prescaler with frequency-test pin

This block turns an oscillator-rate enable (nominally 32768 pulses per second) into a one-second tick pulse. A signed digital trim speeds the tick up or slows it down. The trim is applied over a fixed calibration window of 125,829,120 oscillator pulses, which is 64 minutes at the nominal rate. A speed-up step counts as 512 extra pulses per window, and a slow-down step counts as 256 missing pulses per window. The correction is spread across the window in small chunks, so no single second is distorted by much.

A two-bit control register drives a pin model given as an active-low open-drain enable. In test mode the pin carries a square wave at the oscillator rate divided by 64. This wave is taken ahead of the trim logic, so a measured deviation from 512 Hz reflects only the crystal. Outside test mode the pin is held low or released as the control register says.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: `tick_o` is a single-cycle pulse. It rises only in the clock cycle that follows an edge at which `osc_en_i` was high. With zero trim there is exactly one tick per 2^CNT_W enabled cycles.
- R2: The trim byte is read as follows. Bit 5 is the direction (1 = speed up, 0 = slow down). Bits 4:0 are the step count, 0 to 31. Bits 7:6 have no effect.
- R3: Each speed-up step adds 512 counts to the seconds divider within one window, so a window yields (WIN_CYCLES + 512·steps) / 2^CNT_W ticks.
- R4: Each slow-down step removes 256 counts within one window, so a window yields (WIN_CYCLES − 256·steps) / 2^CNT_W ticks.
- R5: When the test bit is 1, `pin_oe_no` toggles after every 32 enabled cycles, giving a period of 64 enabled cycles. It is 0 for the first 32 enabled cycles after reset. The trim never alters it.
- R6: When the test bit is 0, `pin_oe_no` equals the output bit (0 = pin pulled low, 1 = released). It takes that value in the cycle after the write.
- R7: Reset gives test bit 0 and output bit 1, so `pin_oe_no` = 1. Reset holds `tick_o` low and applies zero trim to the first window.
- R8: `cal_i` is sampled only on the last enabled cycle of each window, and that value governs the whole next window. Any value that is present earlier in a window, and replaced before its end, has no effect.
- R9: A write with `ctrl_we_i` stores bit 7 as the output bit and bit 6 as the test bit. Bits 5:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One-cycle pulse per oscillator period |
| cal_i | input | 8 | Trim byte: direction bit 5, steps 4:0 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control data: output bit 7, test bit 6 |
| tick_o | output | 1 | One-second tick pulse |
| pin_oe_no | output | 1 | Pin pull-down enable, active low |

## Verification
The bench builds the block with WIN_CYCLES = 16384, which gives slots of 16 cycles, and CNT_W = 8, which gives a 256-count second. With these values a whole window runs in about 16k clocks, and every trim setting yields a whole number of ticks per window: 64 base ticks, plus 2 per speed-up step or minus 1 per slow-down step. Exact per-window tick counts therefore expose any lost, duplicated or misplaced adjustment, including a stall that runs past the window end. A decoy trim is applied in the first half of each window to show that only the value present at the window boundary is taken.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SLOT_BITS = 10;           // window split into 2^SLOT_BITS slots
  localparam int MAG_W     = 5;
  localparam int SKIP_LEN  = 32;           // counts jumped per speed-up point
  localparam int SKIP_PTS  = 16;           // speed-up points per step
  localparam int STALL_LEN = 8;            // cycles held per slow-down point
  localparam int STALL_PTS = 32;           // slow-down points per step
  localparam int TEST_DIV_W = 6;           // test wave = osc / 2^TEST_DIV_W

  typedef struct packed {
    logic             pos;
    logic [MAG_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/rtc_win_sched.sv
module rtc_win_sched
  import rtc_cal_pkg::*;
#(
  parameter int WIN_CYCLES = 125829120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  cal_t       cal_i,
  output cal_t       cal_o,
  output logic       skip_o,
  output logic       stall_o
);
  localparam int SLOTS    = 1 << SLOT_BITS;
  localparam int SLOT_CYC = WIN_CYCLES / SLOTS;
  localparam int POS_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int THR_W    = SLOT_BITS + 1;
  localparam int SKIP_SH  = $clog2(SKIP_PTS);
  localparam int STALL_SH = $clog2(STALL_PTS);
  localparam logic [POS_W-1:0]     POS_LAST  = POS_W'(SLOT_CYC - 1);
  localparam logic [SLOT_BITS-1:0] SLOT_LAST = SLOT_BITS'(SLOTS - 1);

  logic [POS_W-1:0]     slot_pos_q;
  logic [SLOT_BITS-1:0] slot_idx_q;
  logic [SLOT_BITS-1:0] slot_rev;
  logic [THR_W-1:0]     thr;
  cal_t                 cal_q;
  logic                 slot_end;
  logic                 win_end;
  logic                 point;

  // bit-reversed slot order spreads the chosen slots evenly
  for (genvar b = 0; b < SLOT_BITS; b++) begin : g_rev
    assign slot_rev[b] = slot_idx_q[SLOT_BITS-1-b];
  end

  assign slot_end = osc_en_i && (slot_pos_q == POS_LAST);
  assign win_end  = slot_end && (slot_idx_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_pos_q <= '0;
      slot_idx_q <= '0;
      cal_q      <= '0;
    end else if (osc_en_i) begin
      if (slot_end) begin
        slot_pos_q <= '0;
        slot_idx_q <= slot_idx_q + 1'b1;
      end else begin
        slot_pos_q <= slot_pos_q + 1'b1;
      end
      if (win_end) cal_q <= cal_i;
    end
  end

  always_comb begin
    if (cal_q.pos) thr = THR_W'(cal_q.mag) << SKIP_SH;
    else           thr = THR_W'(cal_q.mag) << STALL_SH;
  end

  assign point   = osc_en_i && (slot_pos_q == '0) && ({1'b0, slot_rev} < thr);
  assign skip_o  = point && cal_q.pos;
  assign stall_o = point && !cal_q.pos;
  assign cal_o   = cal_q;
endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
  import rtc_cal_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic skip_i,
  input  logic stall_i,
  output logic tick_o
);
  localparam int STL_W = $clog2(STALL_LEN);
  localparam logic [STL_W-1:0] STL_LOAD = STL_W'(STALL_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [STL_W-1:0] stall_q;
  logic [CNT_W:0]   inc;
  logic [CNT_W:0]   sum;
  logic             tick_q;

  always_comb begin
    if (stall_i || (stall_q != '0)) inc = '0;
    else if (skip_i)                inc = (CNT_W+1)'(SKIP_LEN + 1);
    else                            inc = (CNT_W+1)'(1);
    sum = {1'b0, cnt_q} + inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stall_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= osc_en_i && sum[CNT_W];
      if (osc_en_i) begin
        cnt_q <= sum[CNT_W-1:0];
        if (stall_i)             stall_q <= STL_LOAD;
        else if (stall_q != '0)  stall_q <= stall_q - 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_ft_out.sv
module rtc_ft_out
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       we_i,
  input  logic [1:0] wbits_i,   // {out, test}
  output logic       test_sq_o,
  output logic       pin_oe_no
);
  logic [TEST_DIV_W-1:0] div_q;
  logic                  out_q;
  logic                  test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      out_q  <= 1'b1;
      test_q <= 1'b0;
    end else begin
      if (osc_en_i) div_q <= div_q + 1'b1;
      if (we_i) begin
        out_q  <= wbits_i[1];
        test_q <= wbits_i[0];
      end
    end
  end

  assign test_sq_o = div_q[TEST_DIV_W-1];
  assign pin_oe_no = test_q ? test_sq_o : out_q;
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int WIN_CYCLES = 125829120,
  parameter int CNT_W      = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic [7:0] cal_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic       tick_o,
  output logic       pin_oe_no
);
  cal_t cal_in;
  cal_t cal_cur;
  logic cal_pos;
  logic [MAG_W-1:0] cal_mag;
  logic skip;
  logic stall;
  logic test_sq;
  logic unused_bits;

  assign cal_in.pos  = cal_i[MAG_W];
  assign cal_in.mag  = cal_i[MAG_W-1:0];
  assign cal_pos     = cal_cur.pos;
  assign cal_mag     = cal_cur.mag;
  assign unused_bits = ^{cal_i[7:6], ctrl_wdata_i[5:0]};

  rtc_win_sched #(.WIN_CYCLES(WIN_CYCLES)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .cal_i    (cal_in),
    .cal_o    (cal_cur),
    .skip_o   (skip),
    .stall_o  (stall)
  );

  rtc_sec_div #(.CNT_W(CNT_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .skip_i   (skip),
    .stall_i  (stall),
    .tick_o   (tick_o)
  );

  rtc_ft_out u_ft (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_en_i  (osc_en_i),
    .we_i      (ctrl_we_i),
    .wbits_i   (ctrl_wdata_i[7:6]),
    .test_sq_o (test_sq),
    .pin_oe_no (pin_oe_no)
  );
endmodule

// File: rtl/rtc_cal_prescaler_chk.sv
module rtc_cal_prescaler_chk
  import rtc_cal_pkg::*;
#(
  parameter int WIN_CYCLES = 125829120
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osc_en_i,
  input logic             ctrl_we_i,
  input logic [1:0]       ctrl_bits_i,
  input logic             tick_o,
  input logic             pin_oe_no,
  input logic             cal_pos,
  input logic [MAG_W-1:0] cal_mag,
  input logic             test_sq
);
  localparam int WC_W = $clog2(WIN_CYCLES);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_CYCLES - 1);

  logic [WC_W-1:0] win_cnt_q;
  logic [4:0]      half_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q  <= '0;
      half_cnt_q <= '0;
    end else if (osc_en_i) begin
      win_cnt_q  <= (win_cnt_q == WC_LAST) ? '0 : win_cnt_q + 1'b1;
      half_cnt_q <= half_cnt_q + 1'b1;
    end
  end

  AST_TICK_AFTER_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(osc_en_i)); // R1

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1

  AST_PIN_FOLLOWS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_bits_i[0]) |=> (pin_oe_no == $past(ctrl_bits_i[1]))); // R6

  AST_PIN_MOVES_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_no) |-> ($past(osc_en_i) || $past(ctrl_we_i))); // R5

  AST_TEST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && half_cnt_q == 5'd31) |=> (test_sq != $past(test_sq))); // R5

  AST_TEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i || half_cnt_q != 5'd31) |=> $stable(test_sq)); // R5

  AST_CAL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({cal_pos, cal_mag}) |-> $past(osc_en_i && win_cnt_q == WC_LAST)); // R8
endmodule

bind rtc_cal_prescaler rtc_cal_prescaler_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_en_i    (osc_en_i),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_bits_i (ctrl_wdata_i[7:6]),
  .tick_o      (tick_o),
  .pin_oe_no   (pin_oe_no),
  .cal_pos     (cal_pos),
  .cal_mag     (cal_mag),
  .test_sq     (test_sq)
);

// File: tb/rtc_cal_prescaler_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_tb_top;
  localparam int WIN   = 16384;
  localparam int CW    = 8;
  localparam int BASE  = WIN >> CW;   // 64 ticks per untrimmed window
  localparam int NV    = 7;
  localparam logic [7:0] CAL_V [NV] = '{8'h21, 8'h3F, 8'h01, 8'h1F, 8'hE5, 8'h10, 8'hC3};
  localparam int         EXP_V [NV] = '{66, 126, 63, 33, 74, 48, 61};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic [7:0] cal = 8'h00;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wd = 8'h00;
  logic       tick;
  logic       pin;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_cnt;
  int dbl_tick;
  bit prev_tick;

  always #5 clk = ~clk;

  rtc_cal_prescaler #(.WIN_CYCLES(WIN), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .cal_i(cal),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .tick_o(tick), .pin_oe_no(pin)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // osc_en held high; each edge is one oscillator pulse
  task automatic run_osc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (tick) tick_cnt++;
      if (tick && prev_tick) dbl_tick++;
      prev_tick = tick;
    end
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    ctrl_wd = d; ctrl_we = 1'b1;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int last_pin, run_len, changes;
    dbl_tick = 0; prev_tick = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 reset pin released", int'(pin), 1);
    check("R7 reset tick low", int'(tick), 0);

    // window 0 runs on reset trim; later windows use the value present at the previous boundary
    osc_en = 1'b1;
    for (int w = 0; w <= NV; w++) begin
      tick_cnt = 0;
      cal = 8'h3F;                       // decoy, replaced before window end (R8)
      run_osc(WIN / 2);
      cal = (w < NV) ? CAL_V[w] : 8'h00;
      run_osc(WIN / 2);
      if (w == 0) check("R7 R1 first window untrimmed ticks", tick_cnt, BASE);
      else if (CAL_V[w-1][5]) check($sformatf("R3 R2 R8 cal=%02h ticks", CAL_V[w-1]), tick_cnt, EXP_V[w-1]);
      else check($sformatf("R4 R2 R8 cal=%02h ticks", CAL_V[w-1]), tick_cnt, EXP_V[w-1]);
    end
    check("R1 no back-to-back ticks", dbl_tick, 0);
    osc_en = 1'b0;

    // control register and pin
    ctrl_write(8'h00); check("R6 out=0 drives low", int'(pin), 0);
    ctrl_write(8'h80); check("R6 out=1 releases", int'(pin), 1);
    ctrl_write(8'h3F); check("R9 low bits ignored, out=0", int'(pin), 0);
    ctrl_write(8'hBF); check("R9 low bits ignored, out=1", int'(pin), 1);

    // test wave under maximum trim
    cal = 8'h3F;
    ctrl_write(8'h40);
    last_pin = int'(pin);
    repeat (5) @(posedge clk);
    #1 check("R5 test wave holds without osc pulses", int'(pin), last_pin);
    osc_en = 1'b1;
    run_len = 0; changes = 0;
    for (int k = 0; k < 640; k++) begin
      @(posedge clk); #1;
      run_len++;
      if (int'(pin) != last_pin) begin
        if (changes > 0) check("R5 half period 32 osc pulses", run_len, 32);
        changes++; run_len = 0; last_pin = int'(pin);
      end
    end
    check("R5 toggles in 640 pulses", changes, 20);
    osc_en = 1'b0;
    ctrl_write(8'h00); check("R6 leave test mode, out=0", int'(pin), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule